// File: doc/BRIEF.md
# Video Processor Control Register Slave (I2C)

This block is the serial control port of a video processing chip. It watches the clock and data lines of an I2C bus and recognises START and STOP conditions. It shifts in a device address, a sub-address and data, and it acknowledges by pulling the data line low. Seven 8-bit setting registers (hue, filter, contrast, colour system, vertical mode, black levels, output mode) appear as one flat parallel output bus, and every one of them starts at mid-scale.

A write names a sub-address and then sends one or more data bytes. Each further byte goes to the next sub-address. A read always returns the same pair of status bytes, which are built from parallel status inputs and an internal power-on flag. A strap input picks one of two device addresses. The block samples the bus with a fast system clock, so the open-drain pad and glitch filter sit outside it.

Top module: `vidctl_i2c_slave`

## Requirements
- R1: With `addr_sel` low the block acknowledges device address 0x12 (bytes 0x24 write, 0x25 read). With `addr_sel` high it acknowledges 0x16 (bytes 0x2C, 0x2D). Any other address gets no acknowledge and changes no register.
- R2: A write sends the device address, then a sub-address byte that is always acknowledged, then a data byte. That data byte lands in register k, which sits at `regs_o[8k+7:8k]`.
- R3: Each further data byte in the same write goes to the next sub-address.
- R4: After reset every register reads 0x80 and the block does not drive the data line.
- R5: A data byte aimed at a sub-address above 0x06 is not acknowledged and changes no register.
- R6: A read returns byte A = {0, por_ok, col_sys[1:0], xtal_mode[1:0], is_60hz, v_nonstd} and then byte B = {1, h_unlock, noise_hi, y2_ok, uv2_ok, 000}, most significant bit first. The colour code is 00 B/W, 01 SECAM, 10 PAL, 11 NTSC. A read changes no register.
- R7: por_ok reads 0 in the first byte A sent after reset and reads 1 in every byte A after that.
- R8: A STOP returns the block to idle and releases the data line. This includes a read that the master ends with a not-acknowledge after one byte. The next transaction then works normally.
- R9: The block samples the data line on the rising edge of SCL and changes its drive of the data line only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line state |
| sda_i | input | 1 | SDA line state |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | Address strap: 0 selects 0x12, 1 selects 0x16 |
| col_sys | input | 2 | Detected colour system code |
| xtal_mode | input | 2 | Crystal mode code |
| is_60hz | input | 1 | Vertical rate is 60 Hz |
| v_nonstd | input | 1 | Vertical timing is non-standard |
| h_unlock | input | 1 | Horizontal loop is not locked |
| noise_hi | input | 1 | High noise detected |
| y2_ok | input | 1 | Luma input self-test passed |
| uv2_ok | input | 1 | Colour-difference input self-test passed |
| regs_o | output | 56 | Register k on bits 8k+7 to 8k |

## Verification
Two functions can land on the same SCL falling edge. The first is the end of a data byte whose sub-address has run past 0x06, where the block must decide on the acknowledge and on the register write. The second is the auto-increment that moves the pointer to the next sub-address. The bench provokes this with a multi-byte write that starts at sub-address 0x04 and runs into 0x07. It judges the result by the acknowledge seen on each byte and by comparing the whole register bus with a model. A second collision is a STOP that arrives right after a single-byte read with a not-acknowledge. The bench judges it by a write that follows at once and must take effect.

// File: rtl/vidctl_i2c_slave.sv
module vidctl_i2c_slave #(
  parameter int         N_REG     = 7,
  parameter logic [6:0] ADDR_LO   = 7'h12,
  parameter logic [6:0] ADDR_HI   = 7'h16,
  parameter logic [7:0] RESET_VAL = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               addr_sel,
  input  logic [1:0]         col_sys,
  input  logic [1:0]         xtal_mode,
  input  logic               is_60hz,
  input  logic               v_nonstd,
  input  logic               h_unlock,
  input  logic               noise_hi,
  input  logic               y2_ok,
  input  logic               uv2_ok,
  output logic [N_REG*8-1:0] regs_o
);

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_ADDR = 3'd1, S_SUB = 3'd2,
                            S_WR = 3'd3, S_RD = 3'd4} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, ptr;
  logic       in_ack, rd_mode, m_nack, idx, por_ok;
  logic [7:0] regs [N_REG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire scl_hi    = scl_q[1] & scl_q[2];
  wire start_det = scl_hi & sda_q[2] & ~sda_s;
  wire stop_det  = scl_hi & ~sda_q[2] & sda_s;
  wire rx_state  = (st == S_ADDR) || (st == S_SUB) || (st == S_WR);

  wire [6:0] my_addr = addr_sel ? ADDR_HI : ADDR_LO;
  wire [7:0] byte_a  = {1'b0, por_ok, col_sys, xtal_mode, is_60hz, v_nonstd};
  wire [7:0] byte_b  = {1'b1, h_unlock, noise_hi, y2_ok, uv2_ok, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sr      <= '0;
      ptr     <= '0;
      in_ack  <= 1'b0;
      rd_mode <= 1'b0;
      m_nack  <= 1'b0;
      idx     <= 1'b0;
      por_ok  <= 1'b0;
      sda_oe  <= 1'b0;
      for (int i = 0; i < N_REG; i++) regs[i] <= RESET_VAL;
    end else if (start_det) begin
      st     <= S_ADDR;
      cnt    <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (rx_state && !in_ack && cnt < 4'd8) begin
        sr  <= {sr[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end
      if (st == S_RD && in_ack) m_nack <= sda_s;
    end else if (scl_fall) begin
      if (in_ack) begin
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        cnt    <= '0;
        case (st)
          S_ADDR:
            if (rd_mode) begin
              st     <= S_RD;
              idx    <= 1'b0;
              sr     <= byte_a;
              sda_oe <= ~byte_a[7];
              cnt    <= 4'd1;
            end else begin
              st <= S_SUB;
            end
          S_SUB: st <= S_WR;
          S_RD:
            if (m_nack) begin
              st <= S_IDLE;
            end else begin
              idx    <= ~idx;
              sr     <= idx ? byte_a : byte_b;
              sda_oe <= idx ? ~byte_a[7] : ~byte_b[7];
              cnt    <= 4'd1;
            end
          default: ;
        endcase
      end else if (st == S_RD) begin
        if (cnt < 4'd8) begin
          sda_oe <= ~sr[6];
          sr     <= {sr[6:0], 1'b0};
          cnt    <= cnt + 4'd1;
        end else begin
          sda_oe <= 1'b0;
          in_ack <= 1'b1;
          if (!idx) por_ok <= 1'b1;
        end
      end else if (rx_state && cnt == 4'd8) begin
        case (st)
          S_ADDR:
            if (sr[7:1] == my_addr) begin
              rd_mode <= sr[0];
              sda_oe  <= 1'b1;
              in_ack  <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          S_SUB: begin
            ptr    <= sr;
            sda_oe <= 1'b1;
            in_ack <= 1'b1;
          end
          default: begin
            in_ack <= 1'b1;
            if (ptr < 8'(N_REG)) begin
              regs[ptr[$clog2(N_REG)-1:0]] <= sr;
              sda_oe <= 1'b1;
              ptr    <= ptr + 8'd1;
            end
          end
        endcase
      end
    end
  end

  for (genvar k = 0; k < N_REG; k++) begin : g_out
    assign regs_o[8*k +: 8] = regs[k];
  end

endmodule

module vidctl_i2c_slave_chk #(
  parameter int N_REG = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [N_REG*8-1:0] regs_o,
  input logic [2:0]         st,
  input logic [7:0]         ptr,
  input logic               stop_det
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_RD   = 3'd4;

  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_i)
    else $error("R9 sda drive changed with SCL high");

  a_r6_read_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |=> $stable(regs_o))
    else $error("R6 register changed during read");

  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(regs_o) |-> ($past(ptr) < 8'(N_REG)))
    else $error("R5 write outside register range");

  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe))
    else $error("R8 STOP did not return to idle");
endmodule

bind vidctl_i2c_slave vidctl_i2c_slave_chk #(.N_REG(N_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .regs_o(regs_o),
  .st(st), .ptr(ptr), .stop_det(stop_det));

// File: tb/vidctl_i2c_slave_tb.sv
module vidctl_i2c_slave_tb;
  localparam int HP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        addr_sel = 1'b0;
  logic [1:0]  col_sys = 2'b00, xtal_mode = 2'b00;
  logic        is_60hz = 1'b0, v_nonstd = 1'b0, h_unlock = 1'b0;
  logic        noise_hi = 1'b0, y2_ok = 1'b0, uv2_ok = 1'b0;
  logic        sda_oe;
  logic [55:0] regs_o;
  wire         sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, r9_viol = 0;
  bit done = 0;
  logic [7:0] model [7];

  always #4 clk = ~clk;

  vidctl_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .col_sys(col_sys), .xtal_mode(xtal_mode),
    .is_60hz(is_60hz), .v_nonstd(v_nonstd), .h_unlock(h_unlock),
    .noise_hi(noise_hi), .y2_ok(y2_ok), .uv2_ok(uv2_ok), .regs_o(regs_o));

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe !== prev_oe) r9_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    logic [55:0] ev;
    for (int k = 0; k < 7; k++) ev[8*k +: 8] = model[k];
    chk(tag, 64'(regs_o), 64'(ev));
  endtask

  task automatic waith(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; waith(HP); m_scl = 1'b1; waith(HP);
    m_sda = 1'b0; waith(HP); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; waith(HP); m_scl = 1'b1; waith(HP);
    m_sda = 1'b1; waith(HP);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; waith(HP); m_scl = 1'b1; waith(HP); m_scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; waith(HP); m_scl = 1'b1; waith(HP / 2);
    b = sda_line; waith(HP / 2); m_scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  // vector: strap, 7-bit address, sub-address, data, expected address ack, expected data ack
  localparam logic [25:0] VEC [7] = '{
    {1'b0, 7'h12, 8'h00, 8'h11, 1'b1, 1'b1},
    {1'b0, 7'h12, 8'h06, 8'h66, 1'b1, 1'b1},
    {1'b1, 7'h16, 8'h03, 8'h33, 1'b1, 1'b1},
    {1'b1, 7'h12, 8'h02, 8'h22, 1'b0, 1'b0},
    {1'b0, 7'h16, 8'h01, 8'h44, 1'b0, 1'b0},
    {1'b0, 7'h12, 8'h07, 8'h77, 1'b1, 1'b0},
    {1'b0, 7'h12, 8'h01, 8'hA5, 1'b1, 1'b1}
  };

  initial begin
    logic       ack;
    logic [7:0] b0, b1;
    for (int k = 0; k < 7; k++) model[k] = 8'h80;
    waith(5);
    chk("R4 reset registers", 64'(regs_o), 64'({7{8'h80}}));
    chk("R4 reset sda release", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    waith(10);

    for (int v = 0; v < 7; v++) begin
      addr_sel = VEC[v][25];
      waith(4);
      bus_start;
      wbyte({VEC[v][24:18], 1'b0}, ack);
      chk($sformatf("R1 address ack vec%0d", v), 64'(ack), 64'(VEC[v][1]));
      if (ack) begin
        wbyte(VEC[v][17:10], ack);
        chk($sformatf("R2 sub-address ack vec%0d", v), 64'(ack), 64'd1);
        wbyte(VEC[v][9:2], ack);
        chk($sformatf("R2/R5 data ack vec%0d", v), 64'(ack), 64'(VEC[v][0]));
        if (VEC[v][0]) model[VEC[v][17:10]] = VEC[v][9:2];
      end
      bus_stop;
      chk_regs($sformatf("R2/R1/R5 register bus vec%0d", v));
    end

    // R3 and R5: auto-increment running past the last register
    addr_sel = 1'b0;
    waith(4);
    bus_start;
    wbyte(8'h24, ack);
    wbyte(8'h04, ack);
    wbyte(8'hC4, ack); chk("R3 inc byte0 ack", 64'(ack), 64'd1);
    wbyte(8'hC5, ack); chk("R3 inc byte1 ack", 64'(ack), 64'd1);
    wbyte(8'hC6, ack); chk("R3 inc byte2 ack", 64'(ack), 64'd1);
    wbyte(8'hC7, ack); chk("R5 inc past end nack", 64'(ack), 64'd0);
    bus_stop;
    model[4] = 8'hC4; model[5] = 8'hC5; model[6] = 8'hC6;
    chk_regs("R3 auto-increment registers");

    // R6 and R7: first read after reset
    col_sys = 2'b10; xtal_mode = 2'b01; is_60hz = 1'b1; v_nonstd = 1'b0;
    h_unlock = 1'b1; noise_hi = 1'b0; y2_ok = 1'b1; uv2_ok = 1'b0;
    waith(4);
    bus_start;
    wbyte(8'h25, ack);
    chk("R1 read address ack", 64'(ack), 64'd1);
    rbyte(b0, 1'b1);
    rbyte(b1, 1'b0);
    bus_stop;
    chk("R6/R7 first byte A", 64'(b0), 64'({1'b0, 1'b0, 2'b10, 2'b01, 1'b1, 1'b0}));
    chk("R6 byte B", 64'(b1), 64'({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000}));
    chk_regs("R6 read leaves registers");

    // R7: second read shows por_ok set; strap high address
    addr_sel = 1'b1;
    col_sys = 2'b11; xtal_mode = 2'b11; is_60hz = 1'b0; v_nonstd = 1'b1;
    h_unlock = 1'b0; noise_hi = 1'b1; y2_ok = 1'b0; uv2_ok = 1'b1;
    waith(4);
    bus_start;
    wbyte(8'h2D, ack);
    chk("R1 read address ack strap high", 64'(ack), 64'd1);
    rbyte(b0, 1'b1);
    rbyte(b1, 1'b0);
    bus_stop;
    chk("R7 second byte A", 64'(b0), 64'({1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 1'b1}));
    chk("R6 second byte B", 64'(b1), 64'({1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000}));

    // R8: single-byte read ended by NACK, then STOP, then a write
    bus_start;
    wbyte(8'h2D, ack);
    rbyte(b0, 1'b0);
    bus_stop;
    chk("R8 single byte read value", 64'(b0), 64'({1'b0, 1'b1, 2'b11, 2'b11, 1'b0, 1'b1}));
    chk("R8 line released after stop", 64'(sda_oe), 64'd0);
    bus_start;
    wbyte(8'h2C, ack);
    chk("R8 address ack after short read", 64'(ack), 64'd1);
    wbyte(8'h02, ack);
    wbyte(8'h5A, ack);
    chk("R8 data ack after short read", 64'(ack), 64'd1);
    bus_stop;
    model[2] = 8'h5A;
    chk_regs("R8 write after short read");

    chk("R9 drive changes only with SCL low", 64'(r9_viol), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule